// File: doc/BRIEF.md
# Level-Sensitive Interrupt Acknowledge Sequencer

This block sits between an external interrupt source and a processor's trap logic. The source raises a level request and places a 5-bit identifier beside it. Interrupts must be globally enabled and the block must be idle. Under those conditions the block first registers the level. One clock later it starts handling the interrupt. At that edge it freezes the identifier into a register and sends a one-cycle take pulse with that vector ID to the processing side.

The processing side signals the end of the handler with a completion strobe. The block then returns a one-cycle acknowledge pulse. The pulse carries the identifier that was frozen at start, not the one currently on the input. This lets the source move its identifier to a more urgent request while the current one is still being handled. The source must compare the acknowledged ID with the one it wants served. The block does not take a new interrupt between the start and the acknowledge. After the acknowledge it is idle again.

Top module: `irq_ack_unit`

## Requirements
- R1: A request is a level on `irq_req`. A level that is high at only one rising clock edge is never taken.
- R2: When handling starts, `take_o` is high for exactly one cycle. `take_vec_o` then equals the 5-bit `irq_id_in` value sampled at the start edge, for any value from 0 to 31.
- R3: While `irq_en` is low, no interrupt is taken. A level that is still high is taken at the first edge at which `irq_en` is high again.
- R4: Handling never starts at the edge where the level is first seen high. The earliest start is the second consecutive edge with `irq_req` high, so `take_o` is visible in the cycle after that edge.
- R5: Changes on `irq_id_in` after the start edge do not alter `take_vec_o` or the identifier that is later acknowledged.
- R6: A `done_i` high at an edge while handling makes `ack_o` high for exactly the following cycle. During that cycle `ack_id_o` equals the frozen identifier. `ack_id_o` keeps that value afterwards.
- R7: No interrupt is taken between a start and its acknowledge. If `irq_req` stays high, the next start happens at the second edge after the edge that raised `ack_o`.
- R8: While `rst` is high at a clock edge (synchronous, active high), the block returns to idle with `ack_o` and `take_o` low and `ack_id_o` equal to zero. Any interrupt in progress is dropped.
- R9: A `done_i` strobe while no interrupt is being handled produces no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_en | input | 1 | Global interrupt enable |
| irq_req | input | 1 | Level-sensitive interrupt request |
| irq_id_in | input | 5 | Identifier of the pending interrupt |
| done_i | input | 1 | Completion strobe from the processing side |
| take_o | output | 1 | One-cycle pulse: handling of an interrupt starts |
| take_vec_o | output | 5 | Vector ID frozen at the start of handling |
| ack_o | output | 1 | One-cycle acknowledge pulse |
| ack_id_o | output | 5 | Identifier being acknowledged |

## Verification
The bench goes after the start timing first. A design that starts at the first high edge would raise `take_o` a cycle early. A one-cycle glitch on the request would then also be taken. The bench swaps the identifier right after the start. A design that acknowledges the live input would then report the new ID, not the frozen one. Other cases are a request held through the acknowledge, which must be taken again exactly two edges later; a request pending while interrupts are disabled, which a wrong design would take or lose; a stray completion strobe while idle; and a reset in the middle of handling. In these cases a faulty design would send a duplicate take, an extra acknowledge or a stale ID.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

    localparam int IRQ_ID_W = 5;

    typedef logic [IRQ_ID_W-1:0] irq_id_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_ACK  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic    valid;
        irq_id_t id;
    } irq_evt_t;

    // Start is allowed from idle when enabled and the level has been
    // high at the previous edge as well as now.
    function automatic logic start_ok(seq_state_e st, logic en,
                                      logic lvl_q, logic lvl);
        return (st == ST_IDLE) && en && lvl_q && lvl;
    endfunction

endpackage

// File: rtl/irq_level_reg.sv
module irq_level_reg (
    input  logic clk,
    input  logic rst,
    input  logic lvl_in,
    output logic lvl_q
);
    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl_in;
    end
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_ack_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic lvl_q,
    input  logic lvl,
    input  logic done,
    output logic start,
    output logic finish
);
    seq_state_e state_q, state_d;

    always_comb begin
        start   = start_ok(state_q, en, lvl_q, lvl);
        finish  = (state_q == ST_BUSY) && done;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)  state_d = ST_BUSY;
            ST_BUSY: if (finish) state_d = ST_ACK;
            ST_ACK:              state_d = ST_IDLE;
            default:             state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/irq_id_hold.sv
module irq_id_hold
    import irq_ack_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     finish,
    input  irq_id_t  id_in,
    output irq_evt_t take_evt,
    output irq_evt_t ack_evt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            take_evt <= '0;
            ack_evt  <= '0;
        end else begin
            take_evt.valid <= start;
            if (start) take_evt.id <= id_in;
            ack_evt.valid  <= finish;
            if (finish) ack_evt.id <= take_evt.id;
        end
    end
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
    import irq_ack_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                irq_en,
    input  logic                irq_req,
    input  logic [IRQ_ID_W-1:0] irq_id_in,
    input  logic                done_i,
    output logic                take_o,
    output logic [IRQ_ID_W-1:0] take_vec_o,
    output logic                ack_o,
    output logic [IRQ_ID_W-1:0] ack_id_o
);
    logic     lvl_q;
    logic     start;
    logic     finish;
    irq_evt_t take_evt;
    irq_evt_t ack_evt;

    irq_level_reg u_lvl (
        .clk    (clk),
        .rst    (rst),
        .lvl_in (irq_req),
        .lvl_q  (lvl_q)
    );

    irq_seq_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .en     (irq_en),
        .lvl_q  (lvl_q),
        .lvl    (irq_req),
        .done   (done_i),
        .start  (start),
        .finish (finish)
    );

    irq_id_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .finish   (finish),
        .id_in    (irq_id_in),
        .take_evt (take_evt),
        .ack_evt  (ack_evt)
    );

    assign take_o     = take_evt.valid;
    assign take_vec_o = take_evt.id;
    assign ack_o      = ack_evt.valid;
    assign ack_id_o   = ack_evt.id;
endmodule

// File: rtl/irq_ack_chk.sv
module irq_ack_chk
    import irq_ack_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                irq_en,
    input logic                irq_req,
    input logic [IRQ_ID_W-1:0] irq_id_in,
    input logic                done_i,
    input logic                take_o,
    input logic [IRQ_ID_W-1:0] take_vec_o,
    input logic                ack_o,
    input logic [IRQ_ID_W-1:0] ack_id_o
);
    logic          busy_c;
    irq_id_t       last_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_c   <= 1'b0;
            last_vec <= '0;
        end else begin
            if (take_o) begin
                busy_c   <= 1'b1;
                last_vec <= take_vec_o;
            end else if (ack_o) begin
                busy_c <= 1'b0;
            end
        end
    end

    a_r4_two_edges_high: assert property (@(posedge clk) disable iff (rst)
        take_o |-> ($past(irq_req) && $past(irq_req, 2)));

    a_r3_enabled_at_start: assert property (@(posedge clk) disable iff (rst)
        take_o |-> $past(irq_en));

    a_r2_vec_sampled: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (take_vec_o == $past(irq_id_in)));

    a_r2_take_single: assert property (@(posedge clk) disable iff (rst)
        take_o |=> !take_o);

    a_r6_ack_single: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o);

    a_r6_ack_id_frozen: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> (ack_id_o == last_vec));

    a_r5_vec_stable: assert property (@(posedge clk) disable iff (rst)
        busy_c |-> $stable(take_vec_o));

    a_r7_no_take_busy: assert property (@(posedge clk) disable iff (rst)
        take_o |-> !busy_c);

    a_r9_ack_needs_done: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> ($past(done_i) && busy_c));

    a_r8_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (!ack_o && !take_o && ack_id_o == '0));
endmodule

bind irq_ack_unit irq_ack_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_en     (irq_en),
    .irq_req    (irq_req),
    .irq_id_in  (irq_id_in),
    .done_i     (done_i),
    .take_o     (take_o),
    .take_vec_o (take_vec_o),
    .ack_o      (ack_o),
    .ack_id_o   (ack_id_o)
);

// File: tb/irq_ack_unit_tb.sv
`timescale 1ns/1ps
module irq_ack_unit_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       irq_en = 1'b0;
    logic       irq_req = 1'b0;
    logic [4:0] irq_id_in = 5'd0;
    logic       done_i = 1'b0;
    logic       take_o;
    logic [4:0] take_vec_o;
    logic       ack_o;
    logic [4:0] ack_id_o;

    int total = 0;
    int bad   = 0;
    bit ended = 0;
    logic [4:0] tq[$];
    logic [4:0] aq[$];
    logic       prev_ack = 1'b0;

    always #4 clk = ~clk;

    irq_ack_unit u_dut (
        .clk(clk), .rst(rst), .irq_en(irq_en), .irq_req(irq_req),
        .irq_id_in(irq_id_in), .done_i(done_i), .take_o(take_o),
        .take_vec_o(take_vec_o), .ack_o(ack_o), .ack_id_o(ack_id_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Monitor: compares every take and ack with the scoreboard queues.
    always @(negedge clk) begin
        if (!rst && !ended) begin
            if (take_o) begin
                if (tq.size() == 0) chk(0, "R7 unexpected take", int'(take_vec_o), -1);
                else begin
                    logic [4:0] e;
                    e = tq.pop_front();
                    chk(take_vec_o == e, "R2 take vector", int'(take_vec_o), int'(e));
                end
            end
            if (ack_o) begin
                chk(!prev_ack, "R6 ack longer than one cycle", 1, 0);
                if (aq.size() == 0) chk(0, "R9 unexpected ack", int'(ack_id_o), -1);
                else begin
                    logic [4:0] e;
                    e = aq.pop_front();
                    chk(ack_id_o == e, "R6 ack id", int'(ack_id_o), int'(e));
                end
            end
            prev_ack = ack_o;
        end else begin
            prev_ack = 1'b0;
        end
    end

    // Driver: full request/handle/complete sequence.
    task automatic serve(input logic [4:0] id0, input logic [4:0] id1,
                         input int wait_cyc, input bit keep_high);
        step();
        irq_req = 1'b1; irq_id_in = id0;
        tq.push_back(id0); aq.push_back(id0);
        step();
        chk(take_o == 1'b0, "R4 no start at first high edge", int'(take_o), 0);
        step();
        chk(take_o == 1'b1, "R4 start at second high edge", int'(take_o), 1);
        irq_id_in = id1;
        for (int i = 0; i < wait_cyc; i++) begin
            step();
            chk(ack_o == 1'b0, "R7 no ack before done", int'(ack_o), 0);
        end
        done_i = 1'b1;
        step();
        done_i = 1'b0;
        chk(ack_o == 1'b1, "R6 ack after done edge", int'(ack_o), 1);
        chk(ack_id_o == id0, "R5 ack carries frozen id", int'(ack_id_o), int'(id0));
        if (!keep_high) irq_req = 1'b0;
        step();
        chk(ack_o == 1'b0, "R6 ack drops after one cycle", int'(ack_o), 0);
        chk(ack_id_o == id0, "R6 ack id held", int'(ack_id_o), int'(id0));
    endtask

    initial begin
        #1600000;
        if (!ended) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        chk(ack_o == 1'b0 && take_o == 1'b0, "R8 reset outputs low", int'(ack_o), 0);
        chk(ack_id_o == 5'd0, "R8 reset ack id zero", int'(ack_id_o), 0);
        rst = 1'b0;
        irq_en = 1'b1;
        step();

        // Basic, with an ID swap after the start (R5).
        serve(5'd5, 5'd9, 3, 1'b0);
        chk(take_vec_o == 5'd5, "R5 take vector frozen", int'(take_vec_o), 5);
        // Top ID, completion immediately after the take (R2).
        serve(5'd31, 5'd2, 0, 1'b0);
        // ID zero, level kept high across the ack (R7).
        serve(5'd0, 5'd17, 2, 1'b1);
        tq.push_back(5'd17); aq.push_back(5'd17);
        chk(take_o == 1'b0, "R7 no retake first edge after ack", int'(take_o), 0);
        step();
        chk(take_o == 1'b1, "R7 retake second edge after ack", int'(take_o), 1);
        chk(take_vec_o == 5'd17, "R7 retake vector", int'(take_vec_o), 17);
        step();
        done_i = 1'b1; step(); done_i = 1'b0;
        irq_req = 1'b0;
        chk(ack_o == 1'b1 && ack_id_o == 5'd17, "R7 retake ack", int'(ack_id_o), 17);
        repeat (3) step();

        // One-cycle glitch is not taken (R1).
        irq_req = 1'b1; irq_id_in = 5'd3;
        step();
        irq_req = 1'b0;
        for (int i = 0; i < 4; i++) begin
            step();
            chk(take_o == 1'b0, "R1 glitch not taken", int'(take_o), 0);
        end

        // Disabled pending level (R3).
        irq_en = 1'b0; irq_req = 1'b1; irq_id_in = 5'd12;
        for (int i = 0; i < 5; i++) begin
            step();
            chk(take_o == 1'b0, "R3 no take while disabled", int'(take_o), 0);
        end
        tq.push_back(5'd12); aq.push_back(5'd12);
        irq_en = 1'b1;
        step();
        chk(take_o == 1'b1, "R3 taken once enabled", int'(take_o), 1);
        done_i = 1'b1; step(); done_i = 1'b0;
        irq_req = 1'b0;
        chk(ack_id_o == 5'd12, "R3 ack id after enable", int'(ack_id_o), 12);
        repeat (3) step();

        // Stray completion while idle (R9).
        done_i = 1'b1; step(); done_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(ack_o == 1'b0, "R9 stray done ignored", int'(ack_o), 0);
            step();
        end

        // Reset in the middle of handling (R8).
        irq_req = 1'b1; irq_id_in = 5'd22;
        tq.push_back(5'd22);
        step(); step();
        chk(take_o == 1'b1, "R8 take before reset", int'(take_o), 1);
        irq_req = 1'b0;
        step();
        rst = 1'b1;
        step(); step();
        chk(ack_o == 1'b0 && ack_id_o == 5'd0, "R8 reset mid handling", int'(ack_id_o), 0);
        rst = 1'b0;
        done_i = 1'b1; step(); done_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(ack_o == 1'b0, "R8 no ack after reset", int'(ack_o), 0);
            step();
        end

        chk(tq.size() == 0 && aq.size() == 0, "R7 scoreboard drained",
            tq.size() + aq.size(), 0);
        ended = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule